// File: doc/BRIEF.md
# Packet Page Allocator

This block manages the packet numbers of a shared packet memory for an Ethernet controller. Each packet number owns a buffer sized in 256-byte pages. A transmit frame needs enough pages for its bytes plus a 6-byte header. The block keeps a pool of packet numbers and a pool of pages, a transmit queue and a receive queue. A host drives it through an 8-bit command register and a packet-number register. It reads results back from an allocation-result byte and a 16-bit queue status word.

The host writes a command code in bits 7:5 of the command word. The block is busy for exactly one cycle while it carries the command out. If an allocation cannot be met, the result shows a failure and the request stays pending. As soon as enough pages and a free number come back, the block grants the request by itself, writes the new number into the result and raises an allocate interrupt. On the media side, a receive engine pushes numbers of arrived packets into the receive queue. A transmit engine takes the head of the transmit queue. Taking it returns that packet to the pool.

Top module: `pkt_mmu`

## Requirements
- R1: After reset, `busy` is 0, `alloc_irq` is 0, `alloc_result` is 0x80 and `fifo_status` is 0x8080 (both queues empty).
- R2: A command write is taken only while `busy` is 0. `busy` is 1 in the cycle after the write and 0 again one cycle later, when the effect of the command is visible. A write made while `busy` is 1 is dropped.
- R3: Command code 3'b001 (command byte 0x20 | n, where bits 2:0 hold n = pages - 1 and bits 4:3 are ignored) allocates n+1 pages under the lowest free packet number. On success `alloc_result` bit 7 is 0 and bits 4:0 hold the number.
- R4: An allocation fails, with `alloc_result` = 0x80, when no packet number is free or fewer than n+1 of the NUM_PAGES pages are free.
- R5: A failed allocation stays pending. When numbers and pages become available, it is granted without a new command: `alloc_result` shows the number and `alloc_irq` goes to 1. `alloc_irq` stays 1 until `irq_ack` is pulsed.
- R6: Command code 3'b110 (0xC0) pushes the value of the packet-number register onto the transmit queue. `fifo_status` bits 6:0 show the transmit head and bit 7 is 1 when that queue is empty. Entries leave in first-in, first-out order.
- R7: A pulse on `rx_push` appends `rx_pkt` to the receive queue. `fifo_status` bits 14:8 show the receive head and bit 15 is 1 when that queue is empty.
- R8: Command code 3'b100 (0x80) removes the receive head but keeps its number allocated.
- R9: Command code 3'b101 (0xA0) removes the receive head and returns its number and pages to the pool.
- R10: Command code 3'b010 (0x40) frees every number and page, empties both queues, sets `alloc_result` to 0x80, cancels a pending allocation and clears `alloc_irq`.
- R11: Command code 3'b111 (0xE0) empties the transmit queue. The receive queue is left as it is, and the flushed numbers stay allocated.
- R12: A pulse on `tx_take` removes the transmit head and returns its number and pages to the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command byte: code in 7:5, page count minus one in 2:0 |
| pkt_sel_we | input | 1 | Packet-number register write strobe |
| pkt_sel_wdata | input | PNW (5) | Packet number used by the enqueue command |
| irq_ack | input | 1 | Clears the allocate interrupt |
| rx_push | input | 1 | Receive engine appends a packet number |
| rx_pkt | input | PNW (5) | Packet number appended to the receive queue |
| tx_take | input | 1 | Transmit engine consumes and frees the transmit head |
| busy | output | 1 | A command is being executed |
| alloc_result | output | 8 | Bit 7 failed, bits 4:0 granted packet number |
| fifo_status | output | 16 | {rx empty, rx head[6:0], tx empty, tx head[6:0]} |
| alloc_irq | output | 1 | Deferred allocation has been granted |

## Verification
The bench checks that the grant is always the lowest free number, including numbers handed back in the middle of the range. A pool that searched from the top, or that never reused numbers, would report the wrong packet. It tells release apart from free by checking whether the dropped receive head can be allocated again. A design that freed on release would hand that number out twice. The bench exhausts the pool in two ways, by pages with eight-page requests and by numbers with single-page requests, so a page or number counter that is off by one would wrongly grant or refuse the last request. It also checks that a deferred grant fires only after pages come back through a transmit take. A second command written during the busy cycle must not become an extra allocation, and a reset must cancel a pending request so that no stray interrupt fires later.

// File: rtl/pkt_mmu_pkg.sv
package pkt_mmu_pkg;

    localparam int CMD_W        = 8;
    localparam int SIZE_W       = 3;
    localparam int HEAD_FIELD_W = 7;
    localparam logic [7:0] RESULT_FAIL = 8'h80;

    typedef enum logic [2:0] {
        OP_IDLE       = 3'b000,
        OP_ALLOC      = 3'b001,
        OP_RESET      = 3'b010,
        OP_SPARE      = 3'b011,
        OP_RX_RELEASE = 3'b100,
        OP_RX_FREE    = 3'b101,
        OP_TX_ENQ     = 3'b110,
        OP_TX_FLUSH   = 3'b111
    } mmu_op_e;

    typedef struct packed {
        mmu_op_e           op;
        logic [1:0]        spare;
        logic [SIZE_W-1:0] size_m1;
    } mmu_cmd_t;

    function automatic logic [7:0] grant_code(input logic [HEAD_FIELD_W-1:0] num);
        return {1'b0, num};
    endfunction

    function automatic logic [7:0] head_code(input logic empty,
                                             input logic [HEAD_FIELD_W-1:0] num);
        return {empty, empty ? {HEAD_FIELD_W{1'b0}} : num};
    endfunction

endpackage

// File: rtl/pkt_queue.sv
module pkt_queue #(
    parameter int DEPTH = 32,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [AW:0]   count;
    logic          full, do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: a push into a full queue leaves the depth unchanged
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !clr) |=> (count == $past(count)));

    // R8: a pop of an empty queue keeps it empty
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/pkt_pool.sv
module pkt_pool #(
    parameter int NUM_PKTS  = 32,
    parameter int NUM_PAGES = 64,
    parameter int NEED_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic [NEED_W-1:0]           need,
    input  logic                        alloc_go,
    output logic                        fit,
    output logic [$clog2(NUM_PKTS)-1:0] grant,
    input  logic                        free_a_en,
    input  logic [$clog2(NUM_PKTS)-1:0] free_a,
    input  logic                        free_b_en,
    input  logic [$clog2(NUM_PKTS)-1:0] free_b
);
    localparam int PNW = $clog2(NUM_PKTS);
    localparam int FPW = $clog2(NUM_PAGES + 1);

    logic [NUM_PKTS-1:0] used;
    logic [NEED_W-1:0]   pages_of [NUM_PKTS];
    logic [FPW-1:0]      free_pages, next_free;
    logic                any_free, a_ok, b_ok, take;

    always_comb begin
        grant    = '0;
        any_free = 1'b0;
        for (int i = NUM_PKTS - 1; i >= 0; i--) begin
            if (!used[i]) begin
                grant    = PNW'(i);
                any_free = 1'b1;
            end
        end
    end

    assign fit  = any_free && (free_pages >= FPW'(need));
    assign take = alloc_go && fit;
    assign a_ok = free_a_en && used[free_a];
    assign b_ok = free_b_en && used[free_b] && !(free_a_en && free_a == free_b);

    always_comb begin
        next_free = free_pages;
        if (a_ok) next_free = next_free + FPW'(pages_of[free_a]);
        if (b_ok) next_free = next_free + FPW'(pages_of[free_b]);
        if (take) next_free = next_free - FPW'(need);
    end

    always_ff @(posedge clk) begin
        if (take) pages_of[grant] <= need;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            used       <= '0;
            free_pages <= FPW'(NUM_PAGES);
        end else begin
            if (a_ok) used[free_a] <= 1'b0;
            if (b_ok) used[free_b] <= 1'b0;
            if (take) used[grant]  <= 1'b1;
            free_pages <= next_free;
        end
    end

    // R3: a granted number was free in the cycle it is granted
    assert_grant_free_R3: assert property (@(posedge clk) disable iff (rst)
        take |-> !used[grant]);

    // R4: page accounting never exceeds the pool
    assert_page_bound_R4: assert property (@(posedge clk) disable iff (rst)
        free_pages <= FPW'(NUM_PAGES));

endmodule

// File: rtl/pkt_mmu.sv
module pkt_mmu
    import pkt_mmu_pkg::*;
#(
    parameter int NUM_PKTS  = 32,
    parameter int NUM_PAGES = 64,
    parameter int PNW       = $clog2(NUM_PKTS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_we,
    input  logic [7:0]     cmd_wdata,
    input  logic           pkt_sel_we,
    input  logic [PNW-1:0] pkt_sel_wdata,
    input  logic           irq_ack,
    input  logic           rx_push,
    input  logic [PNW-1:0] rx_pkt,
    input  logic           tx_take,
    output logic           busy,
    output logic [7:0]     alloc_result,
    output logic [15:0]    fifo_status,
    output logic           alloc_irq
);
    localparam int NEED_W = SIZE_W + 1;
    localparam int PADW   = HEAD_FIELD_W - PNW;

    mmu_cmd_t          cmd_q;
    logic              exec_q;
    logic [PNW-1:0]    sel_q;
    logic              pend_alloc;
    logic [NEED_W-1:0] pend_need, cmd_need, pool_need;
    logic              do_alloc, do_reset, do_release, do_free, do_enq, do_flush;
    logic              pool_fit, retry, alloc_go;
    logic [PNW-1:0]    grant;
    logic [PNW-1:0]    rx_head, tx_head;
    logic              rx_empty, tx_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            exec_q <= 1'b0;
            cmd_q  <= '0;
        end else if (exec_q) begin
            exec_q <= 1'b0;
        end else if (cmd_we) begin
            exec_q <= 1'b1;
            cmd_q  <= mmu_cmd_t'(cmd_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             sel_q <= '0;
        else if (pkt_sel_we) sel_q <= pkt_sel_wdata;
    end

    assign busy       = exec_q;
    assign do_alloc   = exec_q && cmd_q.op == OP_ALLOC;
    assign do_reset   = exec_q && cmd_q.op == OP_RESET;
    assign do_release = exec_q && cmd_q.op == OP_RX_RELEASE;
    assign do_free    = exec_q && cmd_q.op == OP_RX_FREE;
    assign do_enq     = exec_q && cmd_q.op == OP_TX_ENQ;
    assign do_flush   = exec_q && cmd_q.op == OP_TX_FLUSH;

    assign cmd_need  = NEED_W'(cmd_q.size_m1) + 1'b1;
    assign pool_need = do_alloc ? cmd_need : pend_need;
    assign retry     = pend_alloc && !do_alloc && !do_reset && pool_fit;
    assign alloc_go  = (do_alloc && pool_fit) || retry;

    pkt_pool #(.NUM_PKTS(NUM_PKTS), .NUM_PAGES(NUM_PAGES), .NEED_W(NEED_W)) u_pool (
        .clk       (clk),
        .rst       (rst),
        .clr       (do_reset),
        .need      (pool_need),
        .alloc_go  (alloc_go),
        .fit       (pool_fit),
        .grant     (grant),
        .free_a_en (do_free && !rx_empty),
        .free_a    (rx_head),
        .free_b_en (tx_take && !tx_empty),
        .free_b    (tx_head)
    );

    pkt_queue #(.DEPTH(NUM_PKTS), .W(PNW)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .clr       (do_reset),
        .push      (rx_push),
        .push_data (rx_pkt),
        .pop       (do_release || do_free),
        .head      (rx_head),
        .empty     (rx_empty)
    );

    pkt_queue #(.DEPTH(NUM_PKTS), .W(PNW)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .clr       (do_reset || do_flush),
        .push      (do_enq),
        .push_data (sel_q),
        .pop       (tx_take),
        .head      (tx_head),
        .empty     (tx_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_result <= RESULT_FAIL;
            pend_alloc   <= 1'b0;
            pend_need    <= '0;
            alloc_irq    <= 1'b0;
        end else if (do_reset) begin
            alloc_result <= RESULT_FAIL;
            pend_alloc   <= 1'b0;
            alloc_irq    <= 1'b0;
        end else begin
            if (irq_ack) alloc_irq <= 1'b0;
            if (do_alloc) begin
                if (pool_fit) begin
                    alloc_result <= grant_code({{PADW{1'b0}}, grant});
                    pend_alloc   <= 1'b0;
                end else begin
                    alloc_result <= RESULT_FAIL;
                    pend_alloc   <= 1'b1;
                    pend_need    <= cmd_need;
                end
            end else if (retry) begin
                alloc_result <= grant_code({{PADW{1'b0}}, grant});
                pend_alloc   <= 1'b0;
                alloc_irq    <= 1'b1;
            end
        end
    end

    assign fifo_status = {head_code(rx_empty, {{PADW{1'b0}}, rx_head}),
                          head_code(tx_empty, {{PADW{1'b0}}, tx_head})};

    // R2: execution lasts a single cycle
    assert_busy_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R5: the interrupt only rises out of a pending request
    assert_irq_from_pending_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(alloc_irq) |-> $past(pend_alloc));

    // R10: a reset command leaves empty queues and a failed result
    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
        do_reset |=> (fifo_status == 16'h8080 && alloc_result == RESULT_FAIL && !alloc_irq));

endmodule

// File: tb/pkt_mmu_bench.sv
module pkt_mmu_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_wdata = '0;
    logic       pkt_sel_we = 1'b0;
    logic [4:0] pkt_sel_wdata = '0;
    logic       irq_ack = 1'b0;
    logic       rx_push = 1'b0;
    logic [4:0] rx_pkt = '0;
    logic       tx_take = 1'b0;
    logic       busy;
    logic [7:0] alloc_result;
    logic [15:0] fifo_status;
    logic       alloc_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pkt_mmu u_pkt_mmu (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .pkt_sel_we(pkt_sel_we), .pkt_sel_wdata(pkt_sel_wdata), .irq_ack(irq_ack),
        .rx_push(rx_push), .rx_pkt(rx_pkt), .tx_take(tx_take), .busy(busy),
        .alloc_result(alloc_result), .fifo_status(fifo_status), .alloc_irq(alloc_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic command(input logic [7:0] code);
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = code;
        @(negedge clk);
        cmd_we = 1'b0;
        check("R2 busy during execution", 16'(busy), 16'h1);
        @(negedge clk);
        check("R2 busy released", 16'(busy), 16'h0);
    endtask

    task automatic alloc_expect(input logic [7:0] code, input logic [7:0] exp, input string req);
        command(code);
        check(req, 16'(alloc_result), 16'(exp));
    endtask

    task automatic push_rx(input logic [4:0] num);
        @(negedge clk);
        rx_push = 1'b1; rx_pkt = num;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic select(input logic [4:0] num);
        @(negedge clk);
        pkt_sel_we = 1'b1; pkt_sel_wdata = num;
        @(negedge clk);
        pkt_sel_we = 1'b0;
    endtask

    task automatic take_tx();
        @(negedge clk);
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    task automatic test_reset_state();
        check("R1 busy", 16'(busy), 16'h0);
        check("R1 irq", 16'(alloc_irq), 16'h0);
        check("R1 result", 16'(alloc_result), 16'h0080);
        check("R1 status", fifo_status, 16'h8080);
    endtask

    task automatic test_lowest_first();
        alloc_expect(8'h20, 8'h00, "R3 first grant");
        alloc_expect(8'h20, 8'h01, "R3 second grant");
        alloc_expect(8'h38, 8'h02, "R3 third grant, bits 4:3 ignored");
    endtask

    task automatic test_rx_queue();
        push_rx(5'd0);
        push_rx(5'd2);
        check("R7 rx head", fifo_status, 16'h0080);
        command(8'h80);
        check("R8 release pops head", fifo_status, 16'h0280);
        command(8'hA0);
        check("R9 free empties rx", fifo_status, 16'h8080);
        alloc_expect(8'h20, 8'h02, "R9 freed number reused");
        alloc_expect(8'h20, 8'h03, "R8 released number stays allocated");
    endtask

    task automatic test_tx_queue();
        push_rx(5'd0);
        select(5'd1);
        command(8'hC0);
        select(5'd3);
        command(8'hC0);
        check("R6 tx head first in", fifo_status, 16'h0001);
        take_tx();
        check("R12 take pops head", fifo_status, 16'h0003);
        alloc_expect(8'h20, 8'h01, "R12 taken number returns");
        command(8'hE0);
        check("R11 flush empties tx only", fifo_status, 16'h0080);
        alloc_expect(8'h20, 8'h04, "R11 flushed number stays allocated");
    endtask

    task automatic test_write_while_busy();
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = 8'h20;
        @(negedge clk);
        cmd_wdata = 8'h20;
        @(negedge clk);
        cmd_we = 1'b0;
        check("R2 first write granted", 16'(alloc_result), 16'h0005);
        alloc_expect(8'h20, 8'h06, "R2 write during busy dropped");
    endtask

    task automatic test_reset_command();
        command(8'h40);
        check("R10 queues empty", fifo_status, 16'h8080);
        check("R10 result cleared", 16'(alloc_result), 16'h0080);
        alloc_expect(8'h20, 8'h00, "R10 pool freed");
        command(8'h40);
    endtask

    task automatic test_page_exhaustion();
        for (int i = 0; i < 8; i++)
            alloc_expect(8'h27, 8'(i), "R3 eight-page grant");
        alloc_expect(8'h27, 8'h80, "R4 pages exhausted");
        repeat (3) @(negedge clk);
        check("R5 no irq while short", 16'(alloc_irq), 16'h0);
        select(5'd3);
        command(8'hC0);
        take_tx();
        @(negedge clk);
        check("R5 irq after pages return", 16'(alloc_irq), 16'h1);
        check("R5 deferred grant number", 16'(alloc_result), 16'h0003);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R5 irq acknowledged", 16'(alloc_irq), 16'h0);
        command(8'h40);
    endtask

    task automatic test_number_exhaustion();
        for (int i = 0; i < 32; i++)
            alloc_expect(8'h20, 8'(i), "R3 single-page grant");
        alloc_expect(8'h20, 8'h80, "R4 numbers exhausted");
        command(8'h40);
        repeat (4) @(negedge clk);
        check("R10 pending cancelled", 16'(alloc_irq), 16'h0);
        check("R10 result after reset", 16'(alloc_result), 16'h0080);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset_state();
        test_lowest_first();
        test_rx_queue();
        test_tx_queue();
        test_write_while_busy();
        test_reset_command();
        test_page_exhaustion();
        test_number_exhaustion();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule